// File: doc/BRIEF.md
# I2C Slave Address Recognizer with General Call

This block is the front end of the target side of an I2C controller. While enabled it waits on an idle bus for a START condition. After each START it collects the address byte and decides whether the controller is being addressed. The address byte carries seven address bits, most significant first, and then a direction bit. The seven bits are compared with a programmable own address and with the reserved all-zero general call address.

On a hit the block records the direction bit and pulls SDA low for the acknowledge bit. It then reports whether the controller is now a receiver or a transmitter, and whether the hit came from the general call address. On a miss it leaves SDA released, which the master reads as a NACK, and it ignores the bus until the next START or STOP. SCL and SDA are asynchronous to the system clock. Each is passed through a synchronizer, and edges and bus conditions are found on the system clock. Bits are taken on SCL rising edges.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, and while idle, sda_oe, addressed, slv_tx, gc_flag and match_stb are all 0.
- R2: A START condition (SDA falling while SCL stays high) begins address reception. This holds in every state, including mid-transfer (a repeated START), and it clears addressed, slv_tx and gc_flag.
- R3: The address is the first seven bits after a START, taken MSB first on SCL rising edges. It is compared against own_addr.
- R4: On a hit, sda_oe (1 = pull SDA low) rises on the SCL falling edge after the eighth bit. It falls on the SCL falling edge after the ninth rising edge.
- R5: On a hit the eighth bit sets the mode: slv_tx = 1 for a read (bit = 1), and slv_tx = 0 with addressed = 1 for a write (bit = 0).
- R6: An address of 0000000 is a hit and sets gc_flag = 1. This holds even when it differs from own_addr. An own-address hit leaves gc_flag at 0.
- R7: When neither address matches, sda_oe stays 0 and no flag is set. Later SCL/SDA activity is ignored until the next START or STOP.
- R8: A STOP condition (SDA rising while SCL stays high) clears addressed, slv_tx, gc_flag and sda_oe and returns the block to idle.
- R9: While en is 0, the block never drives SDA, holds every output at 0 and does not react to the bus. After en returns to 1 it waits for a fresh START.
- R10: match_stb is a single-cycle pulse, issued once per hit, in the cycle in which addressed becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; 0 keeps it off the bus |
| scl_i | input | 1 | Asynchronous SCL line level |
| sda_i | input | 1 | Asynchronous SDA line level |
| own_addr | input | ADDR_W | Programmable own address |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge) |
| addressed | output | 1 | Address hit since last START |
| slv_tx | output | 1 | 1 = transmit (read) mode after a hit |
| gc_flag | output | 1 | Hit came from the general call address |
| match_stb | output | 1 | One-cycle pulse on a hit |

## Verification
Two of this block's functions can land in the same system cycle: START detection and the enable falling. The bench drops en in exactly the cycle in which the synchronized SDA fall is seen with SCL high, and then clocks a matching address byte. The behavioural reference model gives the disable priority, so no acknowledge may appear, and the outputs are compared with it on every clock. A repeated START issued while the block holds a completed hit also checks that restart beats the held state.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK_LOW,
    ST_ACK_END,
    ST_HOLD,
    ST_SKIP
  } am_state_t;
endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    start_evt = scl_s & scl_q & sda_q & ~sda_s;
    stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
  end
endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl
  import i2c_am_pkg::*;
#(
  parameter int          ADDR_W  = 7,
  parameter logic [31:0] GC_ADDR = 32'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda_s,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  output logic              sda_oe,
  output logic              addressed,
  output logic              slv_tx,
  output logic              gc_flag,
  output logic              match_stb
);
  localparam int                CNT_W   = $clog2(ADDR_W + 1);
  localparam logic [CNT_W-1:0]  LAST    = CNT_W'(ADDR_W);
  localparam logic [ADDR_W-1:0] GC_CODE = GC_ADDR[ADDR_W-1:0];

  am_state_t         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] shreg;
  logic              hit_own, hit_gc;

  always_comb begin
    hit_own = (shreg == own_addr);
    hit_gc  = (shreg == GC_CODE);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      sda_oe    <= 1'b0;
      addressed <= 1'b0;
      slv_tx    <= 1'b0;
      gc_flag   <= 1'b0;
      match_stb <= 1'b0;
    end else begin
      match_stb <= 1'b0;
      if (start_evt) begin
        state     <= ST_ADDR;
        bit_cnt   <= '0;
        sda_oe    <= 1'b0;
        addressed <= 1'b0;
        slv_tx    <= 1'b0;
        gc_flag   <= 1'b0;
      end else if (stop_evt) begin
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        addressed <= 1'b0;
        slv_tx    <= 1'b0;
        gc_flag   <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_rise) begin
            if (bit_cnt == LAST) begin
              if (hit_own || hit_gc) begin
                state     <= ST_ACK_WAIT;
                addressed <= 1'b1;
                slv_tx    <= sda_s;
                gc_flag   <= hit_gc;
                match_stb <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end else begin
              shreg   <= {shreg[ADDR_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_ACK_WAIT: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK_LOW;
          end
          ST_ACK_LOW: if (scl_rise) state <= ST_ACK_END;
          ST_ACK_END: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  AST_DIS_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sda_oe && !addressed)); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (en && start_evt) |=> (!addressed && !sda_oe && !gc_flag)); // R2
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (en && stop_evt) |=> (!addressed && !sda_oe && !slv_tx)); // R8
  AST_ACK_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> addressed); // R4
  AST_TX_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    slv_tx |-> addressed); // R5
  AST_GC_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    gc_flag |-> addressed); // R6
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    match_stb |=> !match_stb); // R10
  AST_STB_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    match_stb |-> $rose(addressed)); // R10
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int          ADDR_W      = 7,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] GC_ADDR     = 32'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              sda_oe,
  output logic              addressed,
  output logic              slv_tx,
  output logic              gc_flag,
  output logic              match_stb
);
  logic [1:0] bus_s;
  logic       start_evt, stop_evt, scl_rise, scl_fall;

  i2c_am_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({scl_i, sda_i}),
    .dout (bus_s)
  );

  i2c_am_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (bus_s[1]),
    .sda_s     (bus_s[0]),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  i2c_am_ctrl #(.ADDR_W(ADDR_W), .GC_ADDR(GC_ADDR)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .own_addr  (own_addr),
    .sda_s     (bus_s[0]),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_oe    (sda_oe),
    .addressed (addressed),
    .slv_tx    (slv_tx),
    .gc_flag   (gc_flag),
    .match_stb (match_stb)
  );
endmodule

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b1;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [6:0] own_addr = 7'h5A;
  logic       sda_oe, addressed, slv_tx, gc_flag, match_stb;
  logic       sda_line;

  int checks = 0;
  int fails = 0;
  int oe_cycles = 0;
  int stb_count = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_addr_match i_i2c_addr_match (
    .clk(clk), .rst(rst), .en(en), .scl_i(m_scl), .sda_i(sda_line),
    .own_addr(own_addr), .sda_oe(sda_oe), .addressed(addressed),
    .slv_tx(slv_tx), .gc_flag(gc_flag), .match_stb(match_stb)
  );

  // behavioural reference model: bus samples delayed through a queue
  logic [1:0] hist[$];
  int   ph;          // 0 idle 1 addr 2 ackwait 3 acklow 4 ackend 5 hold 6 skip
  int   nbits;
  int   addr_acc;
  logic e_oe, e_addr, e_tx, e_gc, e_stb;

  task automatic model_clear();
    e_oe = 0; e_addr = 0; e_tx = 0; e_gc = 0;
  endtask

  always @(posedge clk) begin
    logic [1:0] c, p;
    logic st, sp, rise, fall;
    if (rst) begin
      hist = '{2'b11, 2'b11, 2'b11, 2'b11};
      ph = 0; nbits = 0; addr_acc = 0; e_stb = 0;
      model_clear();
    end else begin
      hist.push_front({m_scl, sda_line});
      void'(hist.pop_back());
      c = hist[2]; p = hist[3];
      st   = c[1] & p[1] & p[0] & ~c[0];
      sp   = c[1] & p[1] & ~p[0] & c[0];
      rise = c[1] & ~p[1];
      fall = ~c[1] & p[1];
      e_stb = 0;
      if (!en) begin
        ph = 0; nbits = 0; addr_acc = 0; model_clear();
      end else if (st) begin
        ph = 1; nbits = 0; addr_acc = 0; model_clear();
      end else if (sp) begin
        ph = 0; model_clear();
      end else if (ph == 1 && rise) begin
        if (nbits == 7) begin
          if (addr_acc == int'(own_addr) || addr_acc == 0) begin
            ph = 2; e_addr = 1; e_tx = c[0]; e_gc = (addr_acc == 0); e_stb = 1;
          end else ph = 6;
        end else begin
          addr_acc = (addr_acc * 2 + int'(c[0])) % 128;
          nbits++;
        end
      end else if (ph == 2 && fall) begin
        e_oe = 1; ph = 3;
      end else if (ph == 3 && rise) ph = 4;
      else if (ph == 4 && fall) begin
        e_oe = 0; ph = 5;
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 sda_oe", sda_oe, e_oe);
      chk("R5 addressed", addressed, e_addr);
      chk("R5 slv_tx", slv_tx, e_tx);
      chk("R6 gc_flag", gc_flag, e_gc);
      chk("R10 match_stb", match_stb, e_stb);
      if (sda_oe) oe_cycles++;
      if (match_stb) stb_count++;
    end
  end

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1; wait_clk(HALF);
    m_scl = 1; wait_clk(HALF);
    m_sda = 0; wait_clk(HALF);
    m_scl = 0; wait_clk(HALF);
  endtask

  task automatic bus_stop();
    m_sda = 0; wait_clk(HALF);
    m_scl = 1; wait_clk(HALF);
    m_sda = 1; wait_clk(HALF);
  endtask

  task automatic bus_bit(logic b);
    m_sda = b; wait_clk(HALF);
    m_scl = 1; wait_clk(HALF);
    m_scl = 0; wait_clk(HALF);
  endtask

  task automatic bus_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    bus_bit(1'b1);  // acknowledge slot, master releases SDA
  endtask

  task automatic clr_counts();
    oe_cycles = 0; stb_count = 0;
  endtask

  initial begin
    wait_clk(4);
    rst = 0;
    wait_clk(2);
    chk("R1 reset sda_oe", sda_oe, 1'b0);
    chk("R1 reset addressed", addressed, 1'b0);
    chk("R1 reset flags", slv_tx | gc_flag | match_stb, 1'b0);

    // R3 R4 R5: own address write
    clr_counts();
    bus_start(); bus_byte({7'h5A, 1'b0});
    chk("R5 write addressed", addressed, 1'b1);
    chk("R5 write is receive", slv_tx, 1'b0);
    chk("R4 ack driven", oe_cycles > 0, 1'b1);
    chk("R10 one strobe", stb_count == 1, 1'b1);
    chk("R6 own hit no gc", gc_flag, 1'b0);

    // R2: repeated start, read
    clr_counts();
    bus_start();
    chk("R2 restart clears", addressed, 1'b0);
    bus_byte({7'h5A, 1'b1});
    chk("R5 read is transmit", slv_tx, 1'b1);
    chk("R4 ack after restart", oe_cycles > 0, 1'b1);

    // R8: stop clears
    bus_stop(); wait_clk(4);
    chk("R8 stop clears addressed", addressed, 1'b0);
    chk("R8 stop clears tx", slv_tx, 1'b0);

    // R6: general call
    clr_counts();
    bus_start(); bus_byte(8'h00);
    chk("R6 gc flag", gc_flag, 1'b1);
    chk("R6 gc addressed", addressed, 1'b1);
    bus_stop(); wait_clk(4);

    // R7: miss, then matching bits without a START are ignored
    clr_counts();
    bus_start(); bus_byte({7'h5B, 1'b0});
    chk("R7 miss no ack", oe_cycles == 0, 1'b1);
    chk("R7 miss not addressed", addressed, 1'b0);
    bus_byte({7'h5A, 1'b0});
    chk("R7 ignored until start", addressed, 1'b0);
    chk("R7 no strobe", stb_count == 0, 1'b1);
    bus_stop(); wait_clk(4);

    // R3: MSB differs only
    clr_counts();
    bus_start(); bus_byte({7'h1A, 1'b0});
    chk("R3 msb mismatch", addressed, 1'b0);
    bus_stop(); wait_clk(4);

    // R3: new own address, LSB significant
    own_addr = 7'h21;
    clr_counts();
    bus_start(); bus_byte({7'h21, 1'b1});
    chk("R3 new own addr", addressed, 1'b1);
    chk("R5 new addr read", slv_tx, 1'b1);
    bus_stop(); wait_clk(4);
    own_addr = 7'h5A;

    // R9: disabled block ignores a matching transfer
    en = 0; clr_counts();
    bus_start(); bus_byte({7'h5A, 1'b0});
    chk("R9 disabled no ack", oe_cycles == 0, 1'b1);
    chk("R9 disabled not addressed", addressed, 1'b0);
    bus_stop();
    en = 1; wait_clk(4);

    // R9 with R2: enable falls in the START detection cycle
    clr_counts();
    m_sda = 1; wait_clk(HALF);
    m_scl = 1; wait_clk(HALF);
    m_sda = 0;
    wait_clk(2);
    en = 0;
    wait_clk(2);
    en = 1;
    wait_clk(HALF);
    m_scl = 0; wait_clk(HALF);
    bus_byte({7'h5A, 1'b0});
    chk("R9 disable beats start", oe_cycles == 0, 1'b1);
    chk("R9 waits fresh start", addressed, 1'b0);
    bus_stop(); wait_clk(4);

    // recovery after disable
    clr_counts();
    bus_start(); bus_byte({7'h5A, 1'b0});
    chk("R2 recovers after enable", addressed, 1'b1);
    bus_stop(); wait_clk(4);
    chk("R1 idle again", sda_oe | addressed | gc_flag, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule